// File: doc/BRIEF.md
# Register-File Byte AND Execution Unit

This unit carries out one instruction class of a small 8-bit register-file processor: the byte-wide logical AND. A fetcher feeds it an opcode and then its operand bytes over a byte stream. The unit decodes which of six addressing variants the opcode names. It then reads the source and destination bytes from an external 256-entry register file, through direct, indirect or immediate addressing. It writes the AND back into the destination location, updates the flag byte, and raises `done` once the fixed cycle count of that variant has elapsed.

Two kinds of short register reference use a 16-register window. The first is the 4-bit working-register number in the compact forms. The second is any 8-bit address field whose upper nibble carries the escape value 0xE. The window is placed in the register file by the upper bits of the register pointer, given on `win_base`. The register file and the flag register live outside the unit. Reads are combinational: `rf_rdata` answers `rf_raddr` within the same cycle. Writes happen on the clock edge that ends the cycle in which `rf_we` is high.

Top module: `andx_exec_unit`

## Requirements
- R1: Only the opcode bytes 0x52..0x57 start an instruction. Any other byte seen while idle is taken from the stream and dropped. It causes no register-file write, no flag write and no `done`.
- R2: The cycle that accepts the opcode is cycle 1. `done` is high for exactly one cycle: cycle 6 for opcodes 0x52/0x53, and cycle 10 for opcodes 0x54..0x57.
- R3: While idle, `byte_take` follows `byte_valid`. During an instruction, `byte_take` is high only in cycle 2, and also in cycle 3 for the 10-cycle forms.
- R4: Opcodes 0x52 and 0x53 take one operand byte. Its upper nibble is the destination working register and its lower nibble the source. Working register n sits at register-file address `{win_base, n}`.
- R5: For opcodes 0x54/0x55 the source address byte comes first and the destination second. For 0x56/0x57 the destination byte comes first and the immediate source byte second.
- R6: An 8-bit address field whose upper nibble is 0xE addresses working register `{win_base, low nibble}` instead of the location it names.
- R7: In the indirect forms, the indirect operand is addressed through a register. That register's contents give the effective 8-bit address, used unchanged. This covers the source of 0x53 (a working register), the source of 0x55, and the destination of 0x57.
- R8: In the `done` cycle, and in no other cycle, `rf_we` is high with `rf_waddr` equal to the destination and `rf_wdata` equal to source AND destination. The source location is left unchanged.
- R9: `flags_we` is high exactly in the `done` cycle. In `flags_out`, Z (bit 6) is set if and only if the result is zero, S (bit 5) equals result bit 7, and V (bit 4) is 0.
- R10: All other flag bits, including C (bit 7), decimal adjust (bit 3) and H (bit 2), are copied from `flags_in` to `flags_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | 4 | Upper bits of the register pointer; places the working-register window |
| byte_valid | input | 1 | A byte is present on `byte_data` |
| byte_data | input | 8 | Instruction byte stream head |
| byte_take | output | 1 | Head byte is consumed at the end of this cycle |
| rf_raddr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 8 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| flags_in | input | 8 | Current flag register |
| flags_we | output | 1 | Flag register write enable |
| flags_out | output | 8 | New flag register value |
| done | output | 1 | Instruction completes this cycle |

## Verification
The bench builds the unit with its default parameters. These are an 8-bit address, a 4-bit window index, 6 and 10 cycles for the short and long forms, and the 0xE escape enabled, so the escape decode path is part of every run. With those values, each window placement given on `win_base` is within reach, as are escaped fields in both the direct and the indirect positions. Back-to-back instructions with no idle gap can be tried as well, along with source and destination fields that name the same register. A behavioural model predicts the take, write and flag outputs of every cycle from the queued stream bytes and a shadow register file.

// File: rtl/andx_pkg.sv
package andx_pkg;

   // Addressing variants, numbered by distance from the first opcode
   typedef enum logic [2:0] {
      MODE_WW   = 3'd0,   // working reg <- working reg
      MODE_WWI  = 3'd1,   // working reg <- @working reg
      MODE_RR   = 3'd2,   // reg <- reg
      MODE_RRI  = 3'd3,   // reg <- @reg
      MODE_RIM  = 3'd4,   // reg <- immediate
      MODE_IRIM = 3'd5    // @reg <- immediate
   } andx_mode_e;

   localparam int OPC_FIRST_DEF = 8'h52;
   localparam int OPC_COUNT     = 6;

   // Flag byte layout decoded by the surrounding processor
   localparam int FLAG_C_DEF = 7;
   localparam int FLAG_Z_DEF = 6;
   localparam int FLAG_S_DEF = 5;
   localparam int FLAG_V_DEF = 4;

endpackage

// File: rtl/andx_addr_xlat.sv
module andx_addr_xlat #(
   parameter int ADDR_W   = 8,
   parameter int WIN_W    = 4,
   parameter bit ESC_EN   = 1'b1,
   parameter int ESC_CODE = 14
) (
   input  logic [ADDR_W-1:0]       full_field,
   input  logic [WIN_W-1:0]        short_field,
   input  logic                    is_short,
   input  logic [ADDR_W-WIN_W-1:0] win_base,
   output logic [ADDR_W-1:0]       addr
);
   localparam int HI_W = ADDR_W - WIN_W;
   localparam logic [HI_W-1:0] ESC = HI_W'(ESC_CODE);

   logic escaped;

   generate
      if (ESC_EN) begin : g_esc
         assign escaped = (full_field[ADDR_W-1 -: HI_W] == ESC);
      end else begin : g_noesc
         assign escaped = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_short)
         addr = {win_base, short_field};
      else if (escaped)
         addr = {win_base, full_field[WIN_W-1:0]};
      else
         addr = full_field;
   end
endmodule

// File: rtl/andx_logic_core.sv
module andx_logic_core #(
   parameter int DATA_W = 8,
   parameter int FLG_Z  = andx_pkg::FLAG_Z_DEF,
   parameter int FLG_S  = andx_pkg::FLAG_S_DEF,
   parameter int FLG_V  = andx_pkg::FLAG_V_DEF
) (
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] flags_in,
   output logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] flags_out
);
   always_comb begin
      result           = src_val & dst_val;
      flags_out        = flags_in;
      flags_out[FLG_Z] = ~|result;
      flags_out[FLG_S] = result[DATA_W-1];
      flags_out[FLG_V] = 1'b0;
   end
endmodule

// File: rtl/andx_seq.sv
module andx_seq
   import andx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OPC_FIRST    = OPC_FIRST_DEF,
   parameter int SHORT_CYCLES = 6,
   parameter int LONG_CYCLES  = 10,
   parameter int STEP_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output andx_mode_e        mode,
   output logic              is_long,
   output logic              take,
   output logic              last
);
   localparam logic [DATA_W-1:0] OPC_LO = DATA_W'(OPC_FIRST);
   localparam logic [DATA_W-1:0] OPC_HI = DATA_W'(OPC_FIRST + OPC_COUNT - 1);
   localparam logic [STEP_W-1:0] ST2    = STEP_W'(2);
   localparam logic [STEP_W-1:0] ST3    = STEP_W'(3);
   localparam logic [STEP_W-1:0] S_LAST = STEP_W'(SHORT_CYCLES);
   localparam logic [STEP_W-1:0] L_LAST = STEP_W'(LONG_CYCLES);

   logic              accept;
   logic [DATA_W-1:0] mode_ofs;

   assign accept   = !busy && byte_valid && (byte_data >= OPC_LO) && (byte_data <= OPC_HI);
   assign mode_ofs = byte_data - OPC_LO;
   assign is_long  = (mode >= MODE_RR);
   assign last     = busy && (step == (is_long ? L_LAST : S_LAST));
   assign take     = busy ? ((step == ST2) || (is_long && step == ST3)) : byte_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         mode <= MODE_WW;
      end else if (!busy) begin
         if (accept) begin
            busy <= 1'b1;
            step <= ST2;
            mode <= andx_mode_e'(mode_ofs[2:0]);
         end
      end else if (last) begin
         busy <= 1'b0;
         step <= '0;
      end else begin
         step <= step + 1'b1;
      end
   end
endmodule

// File: rtl/andx_exec_unit.sv
module andx_exec_unit
   import andx_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int WIN_W        = 4,
   parameter int OPC_FIRST    = OPC_FIRST_DEF,
   parameter int SHORT_CYCLES = 6,
   parameter int LONG_CYCLES  = 10,
   parameter bit ESC_EN       = 1'b1,
   parameter int ESC_CODE     = 14,
   parameter int FLG_Z        = FLAG_Z_DEF,
   parameter int FLG_S        = FLAG_S_DEF,
   parameter int FLG_V        = FLAG_V_DEF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-WIN_W-1:0] win_base,
   input  logic                    byte_valid,
   input  logic [ADDR_W-1:0]       byte_data,
   output logic                    byte_take,
   output logic [ADDR_W-1:0]       rf_raddr,
   input  logic [ADDR_W-1:0]       rf_rdata,
   output logic                    rf_we,
   output logic [ADDR_W-1:0]       rf_waddr,
   output logic [ADDR_W-1:0]       rf_wdata,
   input  logic [ADDR_W-1:0]       flags_in,
   output logic                    flags_we,
   output logic [ADDR_W-1:0]       flags_out,
   output logic                    done
);
   localparam int DATA_W = ADDR_W;
   localparam int STEP_W = $clog2(LONG_CYCLES + 1);
   localparam logic [STEP_W-1:0] ST2 = STEP_W'(2);
   localparam logic [STEP_W-1:0] ST3 = STEP_W'(3);
   localparam logic [STEP_W-1:0] ST4 = STEP_W'(4);
   localparam logic [STEP_W-1:0] ST5 = STEP_W'(5);
   localparam logic [STEP_W-1:0] ST6 = STEP_W'(6);

   // elaboration-time parameter checks
   generate
      if (SHORT_CYCLES < 6) begin : g_bad_short
         $error("SHORT_CYCLES must leave room for the 5-step short schedule");
      end
      if (LONG_CYCLES < 7) begin : g_bad_long
         $error("LONG_CYCLES must leave room for the 6-step long schedule");
      end
      if (2 * WIN_W > ADDR_W) begin : g_bad_win
         $error("two window indices must fit in one operand byte");
      end
      if (OPC_FIRST + OPC_COUNT > (1 << ADDR_W)) begin : g_bad_opc
         $error("opcode range exceeds the byte width");
      end
   endgenerate

   logic              busy, is_long, last;
   logic [STEP_W-1:0] step;
   andx_mode_e        mode;

   andx_seq #(
      .DATA_W(DATA_W), .OPC_FIRST(OPC_FIRST), .SHORT_CYCLES(SHORT_CYCLES),
      .LONG_CYCLES(LONG_CYCLES), .STEP_W(STEP_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .busy(busy), .step(step), .mode(mode), .is_long(is_long),
      .take(byte_take), .last(last)
   );

   // operand holding registers
   logic [DATA_W-1:0] opnd_a, opnd_b, ptr_q, src_q, dst_q;
   logic [ADDR_W-1:0] dst_addr_q;

   // read address selection
   logic [ADDR_W-1:0] xl_full;
   logic [WIN_W-1:0]  xl_short_f;
   logic              xl_short, use_ptr;
   logic [ADDR_W-1:0] xl_addr;

   always_comb begin
      xl_full    = opnd_a;
      xl_short_f = opnd_a[WIN_W-1:0];
      xl_short   = 1'b0;
      use_ptr    = 1'b0;
      if (!is_long) begin
         if (step == ST3) begin
            xl_short   = 1'b1;                          // source window reg
         end else if (step == ST4) begin
            use_ptr    = 1'b1;                          // indirect source
         end else if (step == ST5) begin
            xl_short   = 1'b1;
            xl_short_f = opnd_a[ADDR_W-1 -: WIN_W];     // destination window reg
         end
      end else begin
         if (step == ST5) begin
            use_ptr = (mode == MODE_RRI);
         end else if (step == ST6) begin
            if (mode == MODE_RR || mode == MODE_RRI)
               xl_full = opnd_b;
            use_ptr = (mode == MODE_IRIM);
         end
      end
   end

   andx_addr_xlat #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .ESC_EN(ESC_EN), .ESC_CODE(ESC_CODE)
   ) xlat_i (
      .full_field(xl_full), .short_field(xl_short_f), .is_short(xl_short),
      .win_base(win_base), .addr(xl_addr)
   );

   assign rf_raddr = use_ptr ? ptr_q : xl_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_a     <= '0;
         opnd_b     <= '0;
         ptr_q      <= '0;
         src_q      <= '0;
         dst_q      <= '0;
         dst_addr_q <= '0;
      end else if (busy) begin
         if (step == ST2)
            opnd_a <= byte_data;
         if (!is_long) begin
            if (step == ST3) begin
               if (mode == MODE_WWI) ptr_q <= rf_rdata;
               else                  src_q <= rf_rdata;
            end
            if (step == ST4 && mode == MODE_WWI)
               src_q <= rf_rdata;
            if (step == ST5) begin
               dst_q      <= rf_rdata;
               dst_addr_q <= rf_raddr;
            end
         end else begin
            if (step == ST3)
               opnd_b <= byte_data;
            if (step == ST4)
               ptr_q <= rf_rdata;
            if (step == ST5) begin
               if (mode == MODE_RR || mode == MODE_RRI) src_q <= rf_rdata;
               else                                     src_q <= opnd_b;
            end
            if (step == ST6) begin
               dst_q      <= rf_rdata;
               dst_addr_q <= rf_raddr;
            end
         end
      end
   end

   logic [DATA_W-1:0] result;

   andx_logic_core #(
      .DATA_W(DATA_W), .FLG_Z(FLG_Z), .FLG_S(FLG_S), .FLG_V(FLG_V)
   ) core_i (
      .src_val(src_q), .dst_val(dst_q), .flags_in(flags_in),
      .result(result), .flags_out(flags_out)
   );

   assign done     = last;
   assign rf_we    = last;
   assign flags_we = last;
   assign rf_waddr = dst_addr_q;
   assign rf_wdata = result;
endmodule

// File: rtl/andx_exec_chk.sv
module andx_exec_chk
   import andx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_take,
   input logic              done,
   input logic              rf_we,
   input logic              flags_we,
   input logic [DATA_W-1:0] rf_wdata,
   input logic [DATA_W-1:0] flags_in,
   input logic [DATA_W-1:0] flags_out
);
   // R8
   write_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we == done);

   // R9
   flag_write_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we == rf_we);

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (flags_out[FLAG_Z_DEF] == (rf_wdata == '0)));

   // R9
   sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (flags_out[FLAG_S_DEF] == rf_wdata[DATA_W-1]));

   // R9
   overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> !flags_out[FLAG_V_DEF]);

   // R10
   carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (flags_out[FLAG_C_DEF] == flags_in[FLAG_C_DEF]));

   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   no_take_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !byte_take);
endmodule

bind andx_exec_unit andx_exec_chk #(.DATA_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .byte_take(byte_take), .done(done),
   .rf_we(rf_we), .flags_we(flags_we), .rf_wdata(rf_wdata),
   .flags_in(flags_in), .flags_out(flags_out)
);

// File: tb/andx_exec_unit_tb_top.sv
`timescale 1ns/1ps
module andx_exec_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] win_base = 4'h0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       byte_take, rf_we, flags_we, done;
   logic [7:0] rf_raddr, rf_rdata, rf_waddr, rf_wdata, flags_out, flags_in;

   always #10 clk = ~clk;   // 50 MHz

   logic [7:0] mem [256];
   logic [7:0] flg = 8'h00;
   logic [7:0] q [$];
   int checks = 0, fails = 0, n_writes = 0;

   assign rf_rdata = mem[rf_raddr];
   assign flags_in = flg;

   andx_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .win_base(win_base),
      .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .flags_in(flags_in),
      .flags_we(flags_we), .flags_out(flags_out), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic refresh();
      byte_valid = (q.size() != 0);
      if (q.size() != 0) byte_data = q[0];
      else               byte_data = 8'h00;
   endtask

   // ---------------- reference model ----------------
   bit         m_busy = 0;
   int         m_cyc = 0, m_len = 0, m_daddr = 0;
   logic [7:0] m_res, m_flags;

   function automatic int wreg(input int n);
      return int'(win_base) * 16 + n;
   endfunction

   function automatic int xl(input int f);
      if ((f >> 4) == 14) return int'(win_base) * 16 + (f & 15);
      return f;
   endfunction

   task automatic start_model();
      int opc, b1, b2, s;
      opc = q[0];
      b1  = (q.size() > 1) ? int'(q[1]) : 0;
      b2  = (q.size() > 2) ? int'(q[2]) : 0;
      case (opc)
         8'h52: begin m_daddr = wreg(b1 >> 4); s = mem[wreg(b1 & 15)]; end
         8'h53: begin m_daddr = wreg(b1 >> 4); s = mem[mem[wreg(b1 & 15)]]; end
         8'h54: begin s = mem[xl(b1)]; m_daddr = xl(b2); end
         8'h55: begin s = mem[mem[xl(b1)]]; m_daddr = xl(b2); end
         8'h56: begin m_daddr = xl(b1); s = b2; end
         default: begin m_daddr = mem[xl(b1)]; s = b2; end
      endcase
      m_res   = 8'(s) & mem[m_daddr];
      m_flags = flg & 8'hAF;
      if (m_res == 8'h00) m_flags[6] = 1'b1;
      m_flags[5] = m_res[7];
      m_len  = (opc < 8'h54) ? 6 : 10;
      m_cyc  = 1;
      m_busy = 1;
   endtask

   // captured outputs for the edge that follows
   bit         c_take, c_we, c_fwe;
   logic [7:0] c_waddr, c_wdata, c_fout;

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_take, e_done;
         e_take = 0; e_done = 0;
         if (m_busy) begin
            m_cyc++;
            e_take = (m_cyc == 2) || (m_cyc == 3 && m_len == 10);
            e_done = (m_cyc == m_len);
         end else if (byte_valid) begin
            e_take = 1;
            if (byte_data >= 8'h52 && byte_data <= 8'h57) start_model();
         end
         check(byte_take === e_take, "R3", "byte_take", byte_take, e_take);
         check(done === e_done, "R2", "done", done, e_done);
         check(rf_we === e_done, "R8", "rf_we", rf_we, e_done);
         check(flags_we === e_done, "R9", "flags_we", flags_we, e_done);
         if (e_done) begin
            check(rf_waddr === 8'(m_daddr), "R8", "rf_waddr", rf_waddr, m_daddr);
            check(rf_wdata === m_res, "R8", "rf_wdata", rf_wdata, m_res);
            check(flags_out === m_flags, "R9", "flags_out", flags_out, m_flags);
            m_busy = 0;
         end
         c_take = byte_take; c_we = rf_we; c_fwe = flags_we;
         c_waddr = rf_waddr; c_wdata = rf_wdata; c_fout = flags_out;
      end else begin
         c_take = 0; c_we = 0; c_fwe = 0;
      end
   end

   always @(posedge clk) begin
      #1;
      if (c_take && q.size() != 0) void'(q.pop_front());
      if (c_we) begin mem[c_waddr] = c_wdata; n_writes++; end
      if (c_fwe) flg = c_fout;
      c_take = 0; c_we = 0; c_fwe = 0;
      refresh();
   end

   // ---------------- stimulus helpers ----------------
   task automatic push3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
      q.push_back(a); q.push_back(b); q.push_back(c); refresh();
   endtask

   task automatic push2(input logic [7:0] a, input logic [7:0] b);
      q.push_back(a); q.push_back(b); refresh();
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400; k++) begin
         @(posedge clk); #3;
         if (!m_busy && q.size() == 0) break;
      end
      @(posedge clk); #3;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      refresh();
      repeat (3) @(negedge clk);
      check(done === 1'b0 && rf_we === 1'b0, "R8", "reset write/done", {done, rf_we}, 0);
      check(flags_we === 1'b0 && byte_take === 1'b0, "R3", "reset take/flags",
            {flags_we, byte_take}, 0);
      @(posedge clk); #3; rst_n = 1'b1;
      @(posedge clk); #3;

      // R5 immediate form, worked example: 0x7B AND 0xC3 = 0x43
      mem[8'h20] = 8'hC3; flg = 8'h00;
      push3(8'h56, 8'h20, 8'h7B); wait_idle();
      check(mem[8'h20] === 8'h43, "R5", "imm result", mem[8'h20], 8'h43);
      check((flg & 8'h70) === 8'h00, "R9", "Z/S/V after example", flg & 8'h70, 0);

      // R4 working-register form with window at 0x30
      win_base = 4'h3; mem[8'h35] = 8'hF0; mem[8'h3A] = 8'h8C;
      push2(8'h52, 8'h5A); wait_idle();
      check(mem[8'h35] === 8'h80, "R4", "window dst", mem[8'h35], 8'h80);
      check(mem[8'h3A] === 8'h8C, "R8", "source untouched", mem[8'h3A], 8'h8C);
      check(flg[5] === 1'b1, "R9", "S from bit7", flg[5], 1);

      // R7 indirect working-register source, zero result
      mem[8'h32] = 8'h90; mem[8'h90] = 8'h0F; mem[8'h31] = 8'hF0;
      push2(8'h53, 8'h12); wait_idle();
      check(mem[8'h31] === 8'h00, "R7", "indirect src", mem[8'h31], 0);
      check(flg[6] === 1'b1, "R9", "Z on zero", flg[6], 1);

      // R5 register order: source first
      mem[8'h40] = 8'hAA; mem[8'h41] = 8'h5F;
      push3(8'h54, 8'h40, 8'h41); wait_idle();
      check(mem[8'h41] === 8'h0A, "R5", "reg-reg dst second", mem[8'h41], 8'h0A);
      check(mem[8'h40] === 8'hAA, "R5", "reg-reg src first", mem[8'h40], 8'hAA);

      // R6 escaped pointer field, indirect register source
      mem[8'h35] = 8'h60; mem[8'h60] = 8'hFF; mem[8'h70] = 8'h81;
      push3(8'h55, 8'hE5, 8'h70); wait_idle();
      check(mem[8'h70] === 8'h81, "R6", "escaped indirect src", mem[8'h70], 8'h81);

      // R7 indirect destination via escaped field, immediate source
      mem[8'h37] = 8'h50; mem[8'h50] = 8'h3C;
      push3(8'h57, 8'hE7, 8'h0F); wait_idle();
      check(mem[8'h50] === 8'h0C, "R7", "indirect dst", mem[8'h50], 8'h0C);
      check(mem[8'h37] === 8'h50, "R7", "pointer reg kept", mem[8'h37], 8'h50);

      // R10 other flag bits preserved
      flg = 8'hFF; mem[8'h22] = 8'h80;
      push3(8'h56, 8'h22, 8'hFF); wait_idle();
      check(flg === 8'hAF, "R10", "flags preserved", flg, 8'hAF);

      // R1 non-AND opcodes are dropped
      begin
         int w0;
         w0 = n_writes;
         push2(8'h42, 8'h10); wait_idle();
         check(n_writes == w0, "R1", "no write for foreign opcode", n_writes, w0);
         check(q.size() == 0, "R1", "foreign bytes consumed", q.size(), 0);
      end

      // mixed back-to-back stream, model-checked each cycle
      for (int batch = 0; batch < 6; batch++) begin
         win_base = 4'($urandom);
         flg = 8'($urandom);
         for (int n = 0; n < 12; n++) begin
            logic [7:0] opc;
            opc = 8'h52 + 8'($urandom_range(0, 5));
            if ($urandom_range(0, 9) == 0) opc = 8'h13;
            if (opc == 8'h13)       begin q.push_back(opc); end
            else if (opc < 8'h54)   push2(opc, 8'($urandom));
            else if ($urandom_range(0, 2) == 0)
               push3(opc, {4'hE, 4'($urandom)}, 8'($urandom));
            else
               push3(opc, 8'($urandom), 8'($urandom));
         end
         refresh();
         wait_idle();
      end

      finish_run();
   end
endmodule